// File: doc/BRIEF.md
# Two-Host Primary Interrupt Aggregator

This block gathers interrupt requests from up to eight secondary interrupt modules and presents them to two independent host processors. Every secondary slot drives one request toward host A and one toward host B. Each host sees its own byte-wide primary status view and its own active-low interrupt pin. Bit n of a status view is the pending request of slot n on that host's line. A host reads its view to find out which secondary module to service.

Some secondary modules have only one request output. For those slots the single request, wired to the host A input, shows up on both lines at once. Slots with no module behind them always read as zero. A test register lets software force status bits on both lines, so the service path can be exercised without a real event. All access goes through a simple byte-wide register port.

Top module: `irq_fanin_dual`

## Requirements
- R1: Reading address 0x01 returns the host A status: for a populated two-line slot n, bit n is the live OR of `req_a[n]` and forced bit n. It is not latched, so it clears as soon as both clear.
- R2: Reading address 0x02 returns the host B status: for a populated two-line slot n, bit n is the live OR of `req_b[n]` and forced bit n.
- R3: For a slot marked single-line in `SHARED_MASK`, `req_a[n]` (OR the forced bit) appears in both status views, and `req_b[n]` has no effect on either view.
- R4: A slot that is clear in `PRESENT_MASK` reads as 0 in both status views, whatever its request inputs and the forced bits are.
- R5: A write to address 0x03 loads the forced bits from the write data, keeping only populated slots. A 1 forces the matching status bit on, and writing 0 removes it. Reading 0x03 returns the stored forced bits.
- R6: `irq_a_n` is low exactly one clock after any host A status bit is set, and high one clock after none is. `irq_b_n` behaves the same way for host B.
- R7: A read of any address other than 0x01, 0x02 and 0x03 returns 0x00.
- R8: Writes to 0x01, 0x02 or any undefined address change neither status view nor the forced bits.
- R9: After reset, both interrupt pins are high, the forced bits are 0 and `reg_rdata` is 0x00.
- R10: `reg_rdata` takes the addressed value on the clock edge that samples `reg_rd` high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_a | input | NUM_MODS | Per-slot request toward host A (sole request of single-line slots) |
| req_b | input | NUM_MODS | Per-slot request toward host B |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_rdata | output | 8 | Read data, registered |
| irq_a_n | output | 1 | Active-low interrupt to host A |
| irq_b_n | output | 1 | Active-low interrupt to host B |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, and that the request inputs are level signals that change only between clock edges. The stimulus drives every input on the falling edge and issues each register access as a one-cycle strobe. It never overlaps a read with a write, so the property that the read data holds its value is only checked in cycles with no read. The request inputs for absent slots and the host B input of the single-line slot are driven high on purpose, because the assertions claim these inputs cannot reach the status views.

// File: rtl/irq_fanin_pkg.sv
package irq_fanin_pkg;

    localparam int REG_W = 8;
    localparam int NUM_LINES = 2;

    localparam logic [7:0] ADDR_STAT_A = 8'h01;
    localparam logic [7:0] ADDR_STAT_B = 8'h02;
    localparam logic [7:0] ADDR_FORCE  = 8'h03;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT_A,
        SEL_STAT_B,
        SEL_FORCE
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] b;
        logic [REG_W-1:0] a;
    } line_pair_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] addr);
        case (addr)
            ADDR_STAT_A: return SEL_STAT_A;
            ADDR_STAT_B: return SEL_STAT_B;
            ADDR_FORCE:  return SEL_FORCE;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] slot_mask(input int n);
        logic [REG_W-1:0] m;
        for (int i = 0; i < REG_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_fanin_route.sv
module irq_fanin_route
    import irq_fanin_pkg::*;
#(
    parameter int               NUM_MODS     = 8,
    parameter logic [REG_W-1:0] PRESENT_MASK = 8'h7F,
    parameter logic [REG_W-1:0] SHARED_MASK  = 8'h40
) (
    input  logic [NUM_MODS-1:0] req_a,
    input  logic [NUM_MODS-1:0] req_b,
    input  logic [REG_W-1:0]    force_bits,
    output line_pair_t          stat
);

    logic [NUM_MODS-1:0] unused_req_b;
    assign unused_req_b = req_b & SHARED_MASK[NUM_MODS-1:0];

    for (genvar i = 0; i < REG_W; i++) begin : g_slot
        if (i >= NUM_MODS) begin : g_beyond
            assign stat.a[i] = 1'b0;
            assign stat.b[i] = 1'b0;
        end else if (!PRESENT_MASK[i]) begin : g_absent
            assign stat.a[i] = 1'b0;
            assign stat.b[i] = 1'b0;
        end else if (SHARED_MASK[i]) begin : g_single
            logic one_req;
            assign one_req   = req_a[i] | force_bits[i];
            assign stat.a[i] = one_req;
            assign stat.b[i] = one_req;
        end else begin : g_dual
            assign stat.a[i] = req_a[i] | force_bits[i];
            assign stat.b[i] = req_b[i] | force_bits[i];
        end
    end

endmodule

// File: rtl/irq_fanin_regs.sv
module irq_fanin_regs
    import irq_fanin_pkg::*;
#(
    parameter int               NUM_MODS     = 8,
    parameter logic [REG_W-1:0] PRESENT_MASK = 8'h7F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  line_pair_t       stat,
    output logic [REG_W-1:0] force_q,
    output logic [7:0]       reg_rdata
);

    localparam logic [REG_W-1:0] KEEP_MASK = PRESENT_MASK & slot_mask(NUM_MODS);

    reg_sel_e sel;
    logic [7:0] rd_mux;

    assign sel = decode_addr(reg_addr);

    always_comb begin
        unique case (sel)
            SEL_STAT_A: rd_mux = stat.a;
            SEL_STAT_B: rd_mux = stat.b;
            SEL_FORCE:  rd_mux = force_q;
            default:    rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= '0;
        end else if (reg_wr && sel == SEL_FORCE) begin
            force_q <= reg_wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= 8'h00;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_fanin_out.sv
module irq_fanin_out
    import irq_fanin_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_LINES-1:0][REG_W-1:0] stat_vec,
    output logic [NUM_LINES-1:0]            irq_n
);

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                irq_n[j] <= 1'b1;
            end else begin
                irq_n[j] <= ~(|stat_vec[j]);
            end
        end
    end

endmodule

// File: rtl/irq_fanin_dual.sv
module irq_fanin_dual
    import irq_fanin_pkg::*;
#(
    parameter int               NUM_MODS     = 8,
    parameter logic [REG_W-1:0] PRESENT_MASK = 8'h7F,
    parameter logic [REG_W-1:0] SHARED_MASK  = 8'h40
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_MODS-1:0] req_a,
    input  logic [NUM_MODS-1:0] req_b,
    input  logic [7:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                reg_wr,
    input  logic                reg_rd,
    output logic [7:0]          reg_rdata,
    output logic                irq_a_n,
    output logic                irq_b_n
);

    line_pair_t stat;
    logic [REG_W-1:0] force_q;
    logic [REG_W-1:0] stat_a;
    logic [REG_W-1:0] stat_b;
    logic [NUM_LINES-1:0] irq_n;

    assign stat_a = stat.a;
    assign stat_b = stat.b;

    irq_fanin_route #(
        .NUM_MODS    (NUM_MODS),
        .PRESENT_MASK(PRESENT_MASK),
        .SHARED_MASK (SHARED_MASK)
    ) u_route (
        .req_a     (req_a),
        .req_b     (req_b),
        .force_bits(force_q),
        .stat      (stat)
    );

    irq_fanin_regs #(
        .NUM_MODS    (NUM_MODS),
        .PRESENT_MASK(PRESENT_MASK)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .stat     (stat),
        .force_q  (force_q),
        .reg_rdata(reg_rdata)
    );

    irq_fanin_out u_out (
        .clk     (clk),
        .rst     (rst),
        .stat_vec({stat_b, stat_a}),
        .irq_n   (irq_n)
    );

    assign irq_a_n = irq_n[0];
    assign irq_b_n = irq_n[1];

endmodule

// File: rtl/irq_fanin_dual_chk.sv
module irq_fanin_dual_chk #(
    parameter logic [7:0] PRESENT_MASK = 8'h7F,
    parameter logic [7:0] SHARED_MASK  = 8'h40
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic       irq_a_n,
    input logic       irq_b_n,
    input logic [7:0] stat_a,
    input logic [7:0] stat_b,
    input logic [7:0] force_q
);

    p_irq_a_on_r6: assert property (@(posedge clk) disable iff (rst)
        (|stat_a) |=> !irq_a_n);
    p_irq_a_off_r6: assert property (@(posedge clk) disable iff (rst)
        !(|stat_a) |=> irq_a_n);
    p_irq_b_on_r6: assert property (@(posedge clk) disable iff (rst)
        (|stat_b) |=> !irq_b_n);
    p_irq_b_off_r6: assert property (@(posedge clk) disable iff (rst)
        !(|stat_b) |=> irq_b_n);

    p_single_mirror_r3: assert property (@(posedge clk) disable iff (rst)
        ((stat_a ^ stat_b) & SHARED_MASK) == 8'h00);

    p_absent_read_a_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 8'h01) |=> (reg_rdata & ~PRESENT_MASK) == 8'h00);
    p_absent_read_b_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 8'h02) |=> (reg_rdata & ~PRESENT_MASK) == 8'h00);

    p_force_load_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 8'h03) |=> force_q == ($past(reg_wdata) & PRESENT_MASK));
    p_force_kept_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == 8'h03) |=> $stable(force_q));

    p_undef_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr != 8'h01 && reg_addr != 8'h02 && reg_addr != 8'h03)
        |=> reg_rdata == 8'h00);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));

    p_reset_pins_r9: assert property (@(posedge clk)
        rst |=> (irq_a_n && irq_b_n && reg_rdata == 8'h00 && force_q == 8'h00));

endmodule

bind irq_fanin_dual irq_fanin_dual_chk #(
    .PRESENT_MASK(PRESENT_MASK),
    .SHARED_MASK (SHARED_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_rdata(reg_rdata),
    .irq_a_n  (irq_a_n),
    .irq_b_n  (irq_b_n),
    .stat_a   (stat_a),
    .stat_b   (stat_b),
    .force_q  (force_q)
);

// File: tb/irq_fanin_dual_tb.sv
module irq_fanin_dual_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_MODS = 8;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NUM_MODS-1:0] req_a = '0;
    logic [NUM_MODS-1:0] req_b = '0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic reg_wr = 1'b0;
    logic reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic irq_a_n;
    logic irq_b_n;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic rd_pending = 1'b0;
    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_fanin_dual #(
        .NUM_MODS    (NUM_MODS),
        .PRESENT_MASK(8'h7F),
        .SHARED_MASK (8'h40)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .req_a    (req_a),
        .req_b    (req_b),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata),
        .irq_a_n  (irq_a_n),
        .irq_b_n  (irq_b_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // driver: one-cycle read strobe, expected value goes to the scoreboard
    task automatic do_read(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        reg_addr = addr;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [7:0] data);
        reg_addr = addr;
        reg_wdata = data;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_pins(input string tag, input logic ea, input logic eb);
        check({tag, " irq_a_n"}, {7'd0, irq_a_n}, {7'd0, ea});
        check({tag, " irq_b_n"}, {7'd0, irq_b_n}, {7'd0, eb});
    endtask

    // monitor: pops one expected item per completed read
    always @(posedge clk) rd_pending <= reg_rd;

    always @(negedge clk) begin
        if (rd_pending) begin
            if (sb_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R10: unexpected read data %02h expected none", reg_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_pins("R9 reset", 1'b1, 1'b1);
        check("R9 rdata", reg_rdata, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        do_read(8'h03, 8'h00, "R9 force cleared");

        // R1 / R6: host A requests on two-line slots
        req_a = 8'h05;
        @(negedge clk);
        check_pins("R6 A only", 1'b0, 1'b1);
        do_read(8'h01, 8'h05, "R1 status A");
        do_read(8'h02, 8'h00, "R2 status B idle");

        // R2
        req_b = 8'h12;
        @(negedge clk);
        check_pins("R6 both", 1'b0, 1'b0);
        do_read(8'h02, 8'h12, "R2 status B");

        // R1 live clear
        req_a = 8'h00;
        @(negedge clk);
        check_pins("R6 A cleared", 1'b1, 1'b0);
        do_read(8'h01, 8'h00, "R1 live clear");
        req_b = 8'h00;
        @(negedge clk);
        check_pins("R6 B cleared", 1'b1, 1'b1);

        // R3: single-line slot 6
        req_a = 8'h40;
        @(negedge clk);
        check_pins("R3 mirror pins", 1'b0, 1'b0);
        do_read(8'h01, 8'h40, "R3 single on A");
        do_read(8'h02, 8'h40, "R3 single on B");
        req_a = 8'h00;
        req_b = 8'h40;
        @(negedge clk);
        check_pins("R3 req_b ignored pins", 1'b1, 1'b1);
        do_read(8'h02, 8'h00, "R3 req_b ignored");
        req_b = 8'h00;

        // R4: absent slot 7
        req_a = 8'h80;
        req_b = 8'h80;
        @(negedge clk);
        check_pins("R4 absent pins", 1'b1, 1'b1);
        do_read(8'h01, 8'h00, "R4 absent A");
        do_read(8'h02, 8'h00, "R4 absent B");

        // R5: test register forces status, absent slot stays 0
        do_write(8'h03, 8'hFF);
        check_pins("R5 forced pins", 1'b0, 1'b0);
        do_read(8'h03, 8'h7F, "R5 force readback");
        do_read(8'h01, 8'h7F, "R5 forced A");
        do_read(8'h02, 8'h7F, "R5 forced B");

        // R7: undefined offsets while status is set
        do_read(8'h00, 8'h00, "R7 addr 00");
        do_read(8'h04, 8'h00, "R7 addr 04");
        do_read(8'hFF, 8'h00, "R7 addr FF");

        do_write(8'h03, 8'h00);
        check_pins("R5 unforced pins", 1'b1, 1'b1);
        do_read(8'h01, 8'h00, "R5 force removed");
        req_a = 8'h00;
        req_b = 8'h00;

        // R8: writes to read-only and undefined addresses ignored
        do_write(8'h01, 8'hFF);
        do_write(8'h02, 8'hFF);
        do_write(8'h07, 8'hFF);
        check_pins("R8 pins", 1'b1, 1'b1);
        do_read(8'h01, 8'h00, "R8 status A");
        do_read(8'h02, 8'h00, "R8 status B");
        do_read(8'h03, 8'h00, "R8 force untouched");

        // R10: read data holds between reads
        req_a = 8'h03;
        @(negedge clk);
        do_read(8'h01, 8'h03, "R10 read");
        req_a = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 hold", reg_rdata, 8'h03);

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10: %0d reads unanswered expected 0", sb_q.size());
        end
        finish_up();
    end

endmodule